// File: doc/BRIEF.md
# Half-Refill Bitstream Prefetch Buffer

This block sits between an external memory that holds a coded bitstream and a variable-length parser that eats that stream a few bits at a time. It reads 16-bit words from the memory into a 128-bit store that is split into two 64-bit halves. It shows the parser a 16-bit window that begins at the parser's current bit position. The parser reports each cycle how many bits it used, from 0 to 16, and the window slides by that amount.

Fetching begins straight after reset. The window is flagged usable, with an active-low flag, once the first half holds four words. A half is fetched again only after the read position has left it, which means all 64 of its bits have been used. Fetching therefore runs at most one half ahead of the parser. At most one half refill is in progress at any time.

Top module: `bsb_prefetch`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next cycle shows `mem_rd_n` = 1 and `win_vld_n` = 1, and the fetch address counter goes back to 0.
- R2: Read strobes (`mem_rd_n` = 0) begin without any request from the parser. The first strobe after reset carries address 0, and each later strobe carries the previous address plus one, with no gaps or repeats.
- R3: `win_vld_n` first falls on the 7th clock edge after reset is released. Exactly 4 read strobes have been issued by then.
- R4: While `win_vld_n` = 0, `win` holds the 16 stream bits that start at bit position N, where N is the total of accepted consume counts since reset. Stream bit 0 is bit 15 of the word at address 0. Bits within a word run from MSB to LSB, and `win[15]` is the earliest bit.
- R5: `consume` is accepted only on cycles where `win_vld_n` = 0. A value above 16 counts as 16. While `win_vld_n` = 1 the position does not move, whatever `consume` carries.
- R6: The read position wraps modulo 128. A window that spans store bit 127 and bit 0 still shows the stream in order.
- R7: A half is refilled only after every bit of it has been consumed. Let W be the number of words fetched and N the bit position. Then 16·W never exceeds 64·(⌊N/64⌋+2).
- R8: With `consume` held at 0 after reset, fetching stops once both halves are full, after exactly 8 strobes.
- R9: Read data is captured during the cycle that follows the cycle in which `mem_rd_n` was low. Data on `mem_rdata` in any other cycle has no effect.
- R10: While `win_vld_n` = 0 and `consume` = 0, the next cycle still shows `win_vld_n` = 0 with `win` unchanged.
- R11: A refill issues its strobes in one run of at most 4 consecutive cycles, and one half is pending at most at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_n | output | 1 | External read strobe, active low |
| mem_addr | output | 17 | External word address |
| mem_rdata | input | 16 | External read data, valid the cycle after a strobe |
| consume | input | 5 | Bits used by the parser this cycle (0 to 16) |
| win | output | 16 | Stream window at the current bit position, earliest bit in bit 15 |
| win_vld_n | output | 1 | Window usable when 0 |

## Verification
The consumer is driven with several patterns, each checked against a model that tracks the bit position and the words fetched:
- A constant 0 shows that the store fills without overfetching.
- A constant 16 drains faster than the fill rate and exposes the stall path, where consume counts arriving while invalid must be dropped.
- Runs of 1 and of 15 walk the pointer through every alignment and across the 127-to-0 wrap.
- Uniformly random counts mix all of these.
- Oversized counts confirm clamping.

The memory model drives garbage outside the one capture cycle, which pins the read latency. A reset in the middle of the run shows that the address and position restart.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_RUN  = 1'b1
  } fetch_st_e;
endpackage

// File: rtl/bsb_fetch_seq.sv
module bsb_fetch_seq
  import bsb_pkg::*;
#(
  parameter  int WORD_W         = 16,
  parameter  int ADDR_W         = 17,
  parameter  int WORDS_PER_HALF = 4,
  localparam int WCNT_W         = $clog2(WORDS_PER_HALF),
  localparam int ICNT_W         = $clog2(WORDS_PER_HALF + 1),
  localparam int SLOT_W         = WCNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        half_full,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [WORD_W-1:0] wr_data,
  output logic              fill_done,
  output logic              fill_half
);
  localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(WORDS_PER_HALF - 1);
  localparam logic [ICNT_W-1:0] ISSUE_MAX = ICNT_W'(WORDS_PER_HALF);

  fetch_st_e         st;
  logic [ICNT_W-1:0] issued;
  logic [WCNT_W-1:0] landed;
  logic              cap_q;
  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FETCH_IDLE;
      issued    <= '0;
      landed    <= '0;
      cap_q     <= 1'b0;
      next_addr <= '0;
      mem_addr  <= '0;
      mem_rd_n  <= 1'b1;
      fill_half <= 1'b0;
    end else begin
      cap_q    <= ~mem_rd_n;
      mem_rd_n <= 1'b1;
      case (st)
        FETCH_IDLE: begin
          if (!half_full[fill_half]) begin
            st     <= FETCH_RUN;
            issued <= '0;
          end
        end
        FETCH_RUN: begin
          if (issued < ISSUE_MAX) begin
            mem_rd_n  <= 1'b0;
            mem_addr  <= next_addr;
            next_addr <= next_addr + 1'b1;
            issued    <= issued + 1'b1;
          end
          if (cap_q) begin
            if (landed == LAST_WORD) begin
              landed    <= '0;
              st        <= FETCH_IDLE;
              fill_half <= ~fill_half;
            end else begin
              landed <= landed + 1'b1;
            end
          end
        end
        default: st <= FETCH_IDLE;
      endcase
    end
  end

  assign wr_en     = cap_q;
  assign wr_slot   = {fill_half, landed};
  assign wr_data   = mem_rdata;
  assign fill_done = cap_q && (landed == LAST_WORD);
endmodule

// File: rtl/bsb_word_store.sv
module bsb_word_store #(
  parameter  int WORD_W = 16,
  parameter  int SLOTS  = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [SLOTS*WORD_W-1:0] flat
);
  logic [WORD_W-1:0] slot_q [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_slot] <= wr_data;
  end

  // slot 0 holds the earliest stream bits at the top of the flat vector
  for (genvar s = 0; s < SLOTS; s++) begin : g_flat
    assign flat[SLOTS*WORD_W-1-s*WORD_W -: WORD_W] = slot_q[s];
  end
endmodule

// File: rtl/bsb_window.sv
module bsb_window #(
  parameter  int STORE_W = 128,
  parameter  int WIN_W   = 16,
  localparam int PTR_W   = $clog2(STORE_W),
  localparam int CNT_W   = $clog2(WIN_W + 1),
  localparam int DBL_W   = STORE_W + WIN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STORE_W-1:0] flat,
  input  logic [CNT_W-1:0]   consume,
  input  logic               set_en,
  input  logic               set_idx,
  output logic [1:0]         half_full,
  output logic [WIN_W-1:0]   win,
  output logic               win_vld_n
);
  logic [PTR_W-1:0] ptr, ptr_nxt, end_pos;
  logic [1:0]       full_nxt;
  logic [CNT_W-1:0] step;
  logic             h_lo, h_hi, ok, leave;
  logic [DBL_W-1:0] dbl, shifted;

  always_comb begin
    end_pos = ptr + PTR_W'(WIN_W - 1);
    h_lo    = ptr[PTR_W-1];
    h_hi    = end_pos[PTR_W-1];
    ok      = half_full[h_lo] & half_full[h_hi];
    step    = (consume > CNT_W'(WIN_W)) ? CNT_W'(WIN_W) : consume;
    ptr_nxt = ptr + (ok ? PTR_W'(step) : '0);
    leave   = ok && (ptr_nxt[PTR_W-1] != h_lo);
    full_nxt = half_full;
    if (leave)  full_nxt[h_lo]    = 1'b0;
    if (set_en) full_nxt[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      half_full <= 2'b00;
    end else begin
      ptr       <= ptr_nxt;
      half_full <= full_nxt;
    end
  end

  assign dbl       = {flat, flat[STORE_W-1 -: WIN_W]};
  assign shifted   = dbl << ptr;
  assign win       = shifted[DBL_W-1 -: WIN_W];
  assign win_vld_n = ~ok;
endmodule

// File: rtl/bsb_prefetch.sv
module bsb_prefetch #(
  parameter  int STORE_W = 128,
  parameter  int WORD_W  = 16,
  parameter  int WIN_W   = 16,
  parameter  int ADDR_W  = 17,
  localparam int SLOTS   = STORE_W / WORD_W,
  localparam int WPH     = SLOTS / 2,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int CNT_W   = $clog2(WIN_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [CNT_W-1:0]  consume,
  output logic [WIN_W-1:0]  win,
  output logic              win_vld_n
);
  logic [1:0]         half_full;
  logic               wr_en, fill_done, fill_half;
  logic [SLOT_W-1:0]  wr_slot;
  logic [WORD_W-1:0]  wr_data;
  logic [STORE_W-1:0] flat;

  bsb_fetch_seq #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .WORDS_PER_HALF(WPH)
  ) u_fetch (
    .clk(clk), .rst(rst), .half_full(half_full), .mem_rdata(mem_rdata),
    .mem_rd_n(mem_rd_n), .mem_addr(mem_addr), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_data(wr_data), .fill_done(fill_done),
    .fill_half(fill_half)
  );

  bsb_word_store #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .flat(flat)
  );

  bsb_window #(.STORE_W(STORE_W), .WIN_W(WIN_W)) u_window (
    .clk(clk), .rst(rst), .flat(flat), .consume(consume),
    .set_en(fill_done), .set_idx(fill_half), .half_full(half_full),
    .win(win), .win_vld_n(win_vld_n)
  );
endmodule

// File: rtl/bsb_prefetch_chk.sv
module bsb_prefetch_chk #(
  parameter  int STORE_W = 128,
  parameter  int WORD_W  = 16,
  parameter  int WIN_W   = 16,
  parameter  int ADDR_W  = 17,
  localparam int HALF    = STORE_W / 2,
  localparam int WPH     = STORE_W / WORD_W / 2,
  localparam int CNT_W   = $clog2(WIN_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  consume,
  input logic [WIN_W-1:0]  win,
  input logic              win_vld_n
);
  logic [31:0]       strobe_cnt, cons_cnt, run_cnt;
  logic [ADDR_W-1:0] last_addr;
  logic              have_last;
  logic [CNT_W-1:0]  took;

  assign took = (consume > CNT_W'(WIN_W)) ? CNT_W'(WIN_W) : consume;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_cnt <= '0;
      cons_cnt   <= '0;
      run_cnt    <= '0;
      last_addr  <= '0;
      have_last  <= 1'b0;
    end else begin
      if (!win_vld_n) cons_cnt <= cons_cnt + 32'(took);
      if (!mem_rd_n) begin
        strobe_cnt <= strobe_cnt + 1;
        run_cnt    <= run_cnt + 1;
        last_addr  <= mem_addr;
        have_last  <= 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (mem_rd_n && win_vld_n));

  // R2
  first_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n && !have_last) |-> (mem_addr == '0));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n && have_last) |-> (mem_addr == last_addr + 1'b1));

  // R7
  no_overfetch_chk: assert property (@(posedge clk) disable iff (rst)
    ((strobe_cnt + {31'b0, ~mem_rd_n}) * WORD_W) <= (((cons_cnt / HALF) + 2) * HALF));

  // R11
  strobe_run_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> (run_cnt < WPH));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_vld_n && consume == '0) |=> (!win_vld_n && $stable(win)));
endmodule

bind bsb_prefetch bsb_prefetch_chk #(
  .STORE_W(STORE_W), .WORD_W(WORD_W), .WIN_W(WIN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .mem_rd_n(mem_rd_n), .mem_addr(mem_addr),
  .consume(consume), .win(win), .win_vld_n(win_vld_n)
);

// File: tb/test_bsb_prefetch.sv
`timescale 1ns/1ps
module test_bsb_prefetch;
  localparam int WPH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd_n;
  logic [16:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [4:0]  consume = '0;
  logic [15:0] win;
  logic        win_vld_n;

  bsb_prefetch i_bsb_prefetch (
    .clk(clk), .rst(rst), .mem_rd_n(mem_rd_n), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .consume(consume), .win(win), .win_vld_n(win_vld_n)
  );

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int bitpos, exp_addr, nstrobe, since_rel, run, mode, ncyc;
  bit pend, first_seen, stalled, prev_ok;
  logic [16:0] pend_addr;
  logic [15:0] prev_win;

  function automatic logic [15:0] word_at(int a);
    int v;
    v = (a * 40503 + 12345) ^ (a >> 3);
    return v[15:0];
  endfunction

  function automatic logic [15:0] exp_win(int pos);
    logic [15:0] r, w;
    for (int j = 0; j < 16; j++) begin
      int b;
      b = pos + j;
      w = word_at(b / 16);
      r[15-j] = w[15 - (b % 16)];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, ncyc);
    end
  endtask

  task automatic cyc();
    int c;
    @(negedge clk);
    ncyc++;
    // R9: data only in the cycle after a strobe, garbage otherwise
    mem_rdata = pend ? word_at(int'(pend_addr)) : 16'hDEAD;
    pend = 1'b0;
    if (rst) begin
      chk(mem_rd_n === 1'b1 && win_vld_n === 1'b1, "R1",
          {30'b0, mem_rd_n, win_vld_n}, 32'h3);
      consume = '0;
      return;
    end
    since_rel++;
    if (!mem_rd_n) begin
      run++;
      chk(mem_addr == exp_addr[16:0], "R2", 32'(mem_addr), exp_addr);
      chk(run <= WPH, "R11", run, WPH);
      pend = 1'b1;
      pend_addr = mem_addr;
      exp_addr++;
      nstrobe++;
      chk(nstrobe * 16 <= ((bitpos / 64) + 2) * 64, "R7", nstrobe, ((bitpos / 64) + 2) * 4);
    end else begin
      run = 0;
    end
    if (!win_vld_n) begin
      if (!first_seen) begin
        first_seen = 1'b1;
        chk(since_rel == 7, "R3", since_rel, 7);
        chk(nstrobe == 4, "R3", nstrobe, 4);
        chk(win == word_at(0), "R9", 32'(win), 32'(word_at(0)));
      end
      if (stalled)
        chk(win == exp_win(bitpos), "R5", 32'(win), 32'(exp_win(bitpos)));
      else if (bitpos % 128 > 112)
        chk(win == exp_win(bitpos), "R6", 32'(win), 32'(exp_win(bitpos)));
      else
        chk(win == exp_win(bitpos), "R4", 32'(win), 32'(exp_win(bitpos)));
      if (prev_ok) chk(win == prev_win, "R10", 32'(win), 32'(prev_win));
      stalled = 1'b0;
    end
    case (mode)
      0: c = 0;
      1: c = 16;
      2: c = $urandom_range(16, 0);
      3: c = 1;
      4: c = 15;
      default: c = 20;
    endcase
    consume = c[4:0];
    prev_ok  = !win_vld_n && c == 0;
    prev_win = win;
    if (!win_vld_n) bitpos += (c > 16) ? 16 : c;
    else if (c != 0) stalled = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    consume = '0;
    repeat (3) cyc();
    rst = 1'b0;
    bitpos = 0; exp_addr = 0; nstrobe = 0; since_rel = 0; run = 0;
    first_seen = 1'b0; stalled = 1'b0; prev_ok = 1'b0; pend = 1'b0;
  endtask

  task automatic run_phase(int m, int n);
    mode = m;
    repeat (n) cyc();
  endtask

  initial begin
    ncyc = 0;
    mode = 0;
    do_reset();
    run_phase(0, 40);
    chk(nstrobe == 8, "R8", nstrobe, 8);
    run_phase(1, 300);
    run_phase(2, 600);
    run_phase(3, 200);
    run_phase(4, 300);
    run_phase(5, 100);
    do_reset();
    run_phase(2, 500);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule